// File: doc/BRIEF.md
# Programmable-Flag Synchronous FIFO

This block is a single-clock first-in first-out buffer for 36-bit words, built on a register array. Besides full and empty status it raises almost-empty and almost-full warnings at thresholds that can be preset at master reset from a small table, or changed later by writing a parallel register or by shifting bits in serially. A mode bit latched at master reset chooses how reads behave. In standard timing a read request fetches the next word into the output register. In fall-through timing the oldest word is presented on the output on its own, with a ready flag.

Two resets are provided. Master reset empties the buffer and loads the mode and both thresholds. Partial reset empties the buffer but keeps whatever mode and thresholds are in force. A retransmit facility records a read position and can later rewind the read side to it, so that data already delivered can be delivered again.

Top module: `prog_flag_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the buffer is emptied, `rd_data` becomes 0, the timing mode is taken from `fwft_sel` (1 = fall-through), and both thresholds are loaded from `preset_sel`. After it, `rd_stat` is 0, `wr_stat` is 1, `almost_empty` is 1.
- R2: `preset_sel` codes 0, 1, 2, 3, 4 give thresholds 8, 16, 64, 256, 1024. Any other code gives 8. A value larger than DEPTH is reduced to DEPTH.
- R3: In standard timing, `rd_stat` is 1 when the buffer holds a word, starting right after the edge that wrote the first one. A clock edge with `rd_en` and `rd_stat` high places the oldest word on `rd_data`. Words come out in the order they were written.
- R4: A write while `wr_stat` is 0 is dropped. A read in standard timing while `rd_stat` is 0 leaves `rd_data` unchanged.
- R5: In fall-through timing, a word written into an empty buffer appears on `rd_data`, with `rd_stat` (output ready) high, one edge after the edge that wrote it, with no read request. An edge with `rd_en` high while `rd_stat` is high consumes the shown word.
- R6: A read and a write on the same edge are both carried out. In standard timing, a read of an empty buffer on the edge that writes its first word is ignored.
- R7: `almost_empty` is 1 while the fill level is at or below the empty threshold. In fall-through timing the word shown on `rd_data` counts toward the fill level.
- R8: `almost_full` is 1 while the free space is at or below the full threshold. Capacity is DEPTH words in standard timing and DEPTH+1 in fall-through timing, where `wr_stat` drops at DEPTH+1 words.
- R9: An edge with `off_we` high loads `off_data` into the empty threshold when `off_sel` is 0, and into the full threshold when `off_sel` is 1. It takes priority over serial loading on the same edge.
- R10: Each edge with `ser_en` high (and `off_we` low) shifts `ser_bit` into a chain made of the empty threshold followed by the full threshold, each OW = clog2(DEPTH)+1 bits, most significant bit first. After 2*OW shifts, the first OW bits form the empty threshold and the last OW bits form the full threshold.
- R11: While `prst_n` is low at an edge, the buffer empties (`rd_stat` 0, `wr_stat` 1, `rd_data` 0). The thresholds and the timing mode keep their values.
- R12: `rt_mark` records the position of the word the consumer would receive next. `rt_go` rewinds the read side to that position and recomputes the flags, and reads and writes on that same edge are ignored. Both are ignored while either reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous master reset, active low |
| prst_n | input | 1 | Synchronous partial reset, active low |
| preset_sel | input | 3 | Threshold preset code, sampled at master reset |
| fwft_sel | input | 1 | Timing mode sampled at master reset (1 = fall-through) |
| off_we | input | 1 | Parallel threshold write strobe |
| off_sel | input | 1 | Parallel target: 0 empty threshold, 1 full threshold |
| off_data | input | OW | Parallel threshold value |
| ser_en | input | 1 | Serial threshold shift enable |
| ser_bit | input | 1 | Serial threshold data bit |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write word |
| rd_en | input | 1 | Read request |
| rt_mark | input | 1 | Record retransmit position |
| rt_go | input | 1 | Rewind read side to recorded position |
| rd_data | output | WIDTH | Read word |
| rd_stat | output | 1 | Standard: not empty. Fall-through: output ready |
| wr_stat | output | 1 | Standard: not full. Fall-through: input ready |
| almost_empty | output | 1 | Fill level at or below empty threshold |
| almost_full | output | 1 | Free space at or below full threshold |

## Verification
The data path is exercised with a short table of mixed write-only, read-only, simultaneous and empty-read cycles, which separates correct ordering from dropped or duplicated words. Long fills to exactly DEPTH and DEPTH+1 words in each timing mode show where the capacity boundary sits and whether the output register is counted in it. Each threshold source (the presets including the clamped and out-of-range codes, parallel writes with a competing serial shift, and a serial stream followed by a partial reset) is checked by stepping the level one word either side of the threshold. Retransmit is driven with a write on the same edge, which shows that the rewind replays only the recorded words.

// File: rtl/pff_pkg.sv
`timescale 1ns/1ps
// Package pff_pkg
// Shared constants and the threshold preset decoder for the programmable-flag FIFO.
// Assumes callers cast the returned integer to their own threshold width.
package pff_pkg;

    localparam int WORD_W       = 36;
    localparam int PRESET_SEL_W = 3;

    // Decode a preset code into a threshold value, limited to the buffer depth.
    function automatic int preset_offset(input logic [PRESET_SEL_W-1:0] sel, input int depth);
        int v;
        case (sel)
            3'd0:    v = 8;
            3'd1:    v = 16;
            3'd2:    v = 64;
            3'd3:    v = 256;
            3'd4:    v = 1024;
            default: v = 8;
        endcase
        if (v > depth) v = depth;
        return v;
    endfunction

endpackage

// File: rtl/pff_cfg.sv
`timescale 1ns/1ps
// Module pff_cfg
// Holds the timing mode and the two flag thresholds. Master reset loads them from
// the preset code and mode select; partial reset freezes them; otherwise parallel
// writes (priority) or a serial shift chain update the thresholds.
// Assumes both resets are synchronous and active low.
module pff_cfg
    import pff_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int OW = $clog2(DEPTH) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prst_n,
    input  logic [PRESET_SEL_W-1:0] preset_sel,
    input  logic                    fwft_sel,
    input  logic                    off_we,
    input  logic                    off_sel,
    input  logic [OW-1:0]           off_data,
    input  logic                    ser_en,
    input  logic                    ser_bit,
    output logic                    fwft,
    output logic [OW-1:0]           ae_off,
    output logic [OW-1:0]           af_off
);

    logic [OW-1:0] preset_val;

    // Preset threshold for the current code.
    always_comb preset_val = OW'(preset_offset(preset_sel, DEPTH));

    // Mode and threshold registers with reset load, parallel write and serial shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwft   <= fwft_sel;
            ae_off <= preset_val;
            af_off <= preset_val;
        end else if (prst_n) begin
            if (off_we) begin
                if (off_sel) af_off <= off_data;
                else         ae_off <= off_data;
            end else if (ser_en) begin
                {ae_off, af_off} <= {ae_off[OW-2:0], af_off, ser_bit};
            end
        end
    end

endmodule

// File: rtl/pff_store.sv
`timescale 1ns/1ps
// Module pff_store
// Register-array storage with write/read pointers, an occupancy counter, the read
// output register, the fall-through prefetch and the retransmit mark.
// Assumes the producer respects the full status; retransmit replays correctly only
// while the marked words have not been overwritten.
module pff_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 36,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic             fwft,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rt_mark,
    input  logic             rt_go,
    output logic [WIDTH-1:0] rd_data,
    output logic [PW-1:0]    count,
    output logic             out_valid
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr;
    logic [PW-1:0]    rptr;
    logic [PW-1:0]    mark;
    logic             clr;
    logic             wr_ok;
    logic             pop;
    logic             has_data;

    // Either reset clears the data path.
    assign clr      = !rst_n || !prst_n;
    assign has_data = (count != '0);
    assign wr_ok    = wr_en && !rt_go && (count < PW'(DEPTH));

    // Decide when a word leaves the array: on request, or by prefetch in fall-through.
    always_comb begin
        if (fwft) pop = has_data && (!out_valid || rd_en) && !rt_go;
        else      pop = has_data && rd_en && !rt_go;
    end

    // Array write port.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr[AW-1:0]] <= wr_data;
    end

    // Pointers, occupancy, output-valid and retransmit mark.
    always_ff @(posedge clk) begin
        if (clr) begin
            wptr      <= '0;
            rptr      <= '0;
            mark      <= '0;
            count     <= '0;
            out_valid <= 1'b0;
        end else if (rt_go) begin
            rptr      <= mark;
            count     <= wptr - mark;
            out_valid <= 1'b0;
        end else begin
            if (wr_ok) wptr <= wptr + PW'(1);
            if (pop)   rptr <= rptr + PW'(1);
            count <= count + PW'(wr_ok) - PW'(pop);
            if (!fwft)       out_valid <= 1'b0;
            else if (pop)    out_valid <= 1'b1;
            else if (rd_en)  out_valid <= 1'b0;
            if (rt_mark) mark <= rptr - PW'(fwft && out_valid);
        end
    end

    // Read output register.
    always_ff @(posedge clk) begin
        if (clr)      rd_data <= '0;
        else if (pop) rd_data <= mem[rptr[AW-1:0]];
    end

endmodule

// File: rtl/pff_status.sv
`timescale 1ns/1ps
// Module pff_status
// Combinational status: ready/empty and room/full in the chosen timing mode, and
// the two threshold comparisons on fill level and free space.
// Assumes count never exceeds DEPTH.
module pff_status #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int OW = AW + 1,
    localparam int LW = AW + 2
) (
    input  logic          fwft,
    input  logic [PW-1:0] count,
    input  logic          out_valid,
    input  logic [OW-1:0] ae_off,
    input  logic [OW-1:0] af_off,
    output logic          rd_stat,
    output logic          wr_stat,
    output logic          almost_empty,
    output logic          almost_full
);

    logic [LW-1:0] level;
    logic [LW-1:0] cap;
    logic [LW-1:0] room;

    // Fill level including the shown word, capacity, and free space.
    always_comb begin
        level = LW'(count) + LW'(fwft && out_valid);
        cap   = LW'(DEPTH) + LW'(fwft);
        room  = cap - level;
    end

    // Flag outputs.
    always_comb begin
        rd_stat      = fwft ? out_valid : (count != '0);
        wr_stat      = (count < PW'(DEPTH));
        almost_empty = (level <= LW'(ae_off));
        almost_full  = (room <= LW'(af_off));
    end

endmodule

// File: rtl/prog_flag_fifo.sv
`timescale 1ns/1ps
// Module prog_flag_fifo
// Top level of the single-clock FIFO with programmable almost flags, two timing
// modes, master/partial reset and retransmit. Connects configuration, storage
// and status. Assumes DEPTH is a power of two and at least 8.
module prog_flag_fifo
    import pff_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = WORD_W,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int OW = AW + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prst_n,
    input  logic [PRESET_SEL_W-1:0] preset_sel,
    input  logic                    fwft_sel,
    input  logic                    off_we,
    input  logic                    off_sel,
    input  logic [OW-1:0]           off_data,
    input  logic                    ser_en,
    input  logic                    ser_bit,
    input  logic                    wr_en,
    input  logic [WIDTH-1:0]        wr_data,
    input  logic                    rd_en,
    input  logic                    rt_mark,
    input  logic                    rt_go,
    output logic [WIDTH-1:0]        rd_data,
    output logic                    rd_stat,
    output logic                    wr_stat,
    output logic                    almost_empty,
    output logic                    almost_full
);

    logic          fwft;
    logic [OW-1:0] ae_off;
    logic [OW-1:0] af_off;
    logic [PW-1:0] count;
    logic          out_valid;

    pff_cfg #(.DEPTH(DEPTH)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .prst_n     (prst_n),
        .preset_sel (preset_sel),
        .fwft_sel   (fwft_sel),
        .off_we     (off_we),
        .off_sel    (off_sel),
        .off_data   (off_data),
        .ser_en     (ser_en),
        .ser_bit    (ser_bit),
        .fwft       (fwft),
        .ae_off     (ae_off),
        .af_off     (af_off)
    );

    pff_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prst_n    (prst_n),
        .fwft      (fwft),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rt_mark   (rt_mark),
        .rt_go     (rt_go),
        .rd_data   (rd_data),
        .count     (count),
        .out_valid (out_valid)
    );

    pff_status #(.DEPTH(DEPTH)) u_status (
        .fwft         (fwft),
        .count        (count),
        .out_valid    (out_valid),
        .ae_off       (ae_off),
        .af_off       (af_off),
        .rd_stat      (rd_stat),
        .wr_stat      (wr_stat),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

endmodule

// File: rtl/pff_checker.sv
`timescale 1ns/1ps
// Module pff_checker
// Temporal properties of prog_flag_fifo, attached through bind. Observes ports and
// the internal occupancy, output-valid, mode and threshold nets.
module pff_checker #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int OW = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rt_go,
    input logic          rd_stat,
    input logic          wr_stat,
    input logic          fwft,
    input logic [PW-1:0] count,
    input logic          out_valid,
    input logic [OW-1:0] ae_off,
    input logic [OW-1:0] af_off
);

    assert_partial_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(prst_n) |-> (!rd_stat && wr_stat));

    assert_keep_offsets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> ($stable(ae_off) && $stable(af_off)));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && !wr_stat && !rd_en && !rt_go && (!fwft || out_valid)) |=> !wr_stat);

    assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && !rd_stat && !wr_en && !rt_go && (count == '0)) |=> !rd_stat);

    assert_fall_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && fwft && !rt_go && (count != '0) && !out_valid) |=> rd_stat);

    assert_rewind_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_n && rt_go) |=> !out_valid);

endmodule

bind prog_flag_fifo pff_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prst_n    (prst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rt_go     (rt_go),
    .rd_stat   (rd_stat),
    .wr_stat   (wr_stat),
    .fwft      (fwft),
    .count     (count),
    .out_valid (out_valid),
    .ae_off    (ae_off),
    .af_off    (af_off)
);

// File: tb/prog_flag_fifo_test.sv
`timescale 1ns/1ps
module prog_flag_fifo_test;

    localparam int DEPTH = 64;
    localparam int OW    = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [35:0] din;
        logic        e_rs;
        logic [35:0] e_dout;
        logic        e_ae;
    } vec_t;

    // Standard timing, preset code 0 (thresholds 8), starting empty.
    localparam vec_t VEC [0:7] = '{
        '{1'b1, 1'b0, 36'h11, 1'b1, 36'h00, 1'b1},
        '{1'b1, 1'b0, 36'h22, 1'b1, 36'h00, 1'b1},
        '{1'b1, 1'b1, 36'h33, 1'b1, 36'h11, 1'b1},
        '{1'b0, 1'b1, 36'h00, 1'b1, 36'h22, 1'b1},
        '{1'b0, 1'b1, 36'h00, 1'b0, 36'h33, 1'b1},
        '{1'b0, 1'b1, 36'h00, 1'b0, 36'h33, 1'b1},
        '{1'b1, 1'b1, 36'h44, 1'b1, 36'h33, 1'b1},
        '{1'b0, 1'b1, 36'h00, 1'b0, 36'h44, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n, prst_n, fwft_sel, off_we, off_sel, ser_en, ser_bit;
    logic [2:0]    preset_sel;
    logic [OW-1:0] off_data;
    logic          wr_en, rd_en, rt_mark, rt_go;
    logic [35:0]   wr_data, rd_data;
    logic          rd_stat, wr_stat, almost_empty, almost_full;

    int n_checks = 0;
    int n_err    = 0;
    int next_val = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    prog_flag_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .preset_sel(preset_sel),
        .fwft_sel(fwft_sel), .off_we(off_we), .off_sel(off_sel), .off_data(off_data),
        .ser_en(ser_en), .ser_bit(ser_bit), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rt_mark(rt_mark), .rt_go(rt_go), .rd_data(rd_data),
        .rd_stat(rd_stat), .wr_stat(wr_stat), .almost_empty(almost_empty),
        .almost_full(almost_full)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic mreset(input logic [2:0] sel, input logic f);
        rst_n = 1'b0; preset_sel = sel; fwft_sel = f;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic preset_clear();
        prst_n = 1'b0; tick(); prst_n = 1'b1;
    endtask

    task automatic write_n(input int n);
        for (int i = 0; i < n; i++) begin
            wr_en = 1'b1; wr_data = 36'(next_val); next_val++;
            tick();
        end
        wr_en = 1'b0;
    endtask

    task automatic read1();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; prst_n = 1'b1; preset_sel = 3'd0; fwft_sel = 1'b0;
        off_we = 1'b0; off_sel = 1'b0; off_data = '0; ser_en = 1'b0; ser_bit = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; rt_mark = 1'b0; rt_go = 1'b0; wr_data = '0;

        // R1 reset state
        mreset(3'd0, 1'b0);
        chk("R1 rd_stat", 36'(rd_stat), 36'd0);
        chk("R1 wr_stat", 36'(wr_stat), 36'd1);
        chk("R1 almost_empty", 36'(almost_empty), 36'd1);
        chk("R1 almost_full", 36'(almost_full), 36'd0);
        chk("R1 rd_data", rd_data, 36'd0);

        // R3 R4 R6 vector table
        for (int i = 0; i < 8; i++) begin
            wr_en = VEC[i].wr; rd_en = VEC[i].rd; wr_data = VEC[i].din;
            tick();
            wr_en = 1'b0; rd_en = 1'b0;
            chk("R3 table rd_stat", 36'(rd_stat), 36'(VEC[i].e_rs));
            chk("R6 table rd_data", rd_data, VEC[i].e_dout);
            chk("R7 table almost_empty", 36'(almost_empty), 36'(VEC[i].e_ae));
        end

        // R2 R7 R8 R4 preset 16, fill to full, drop extra, drain in order
        mreset(3'd1, 1'b0);
        next_val = 100;
        write_n(16);
        chk("R7 ae at 16", 36'(almost_empty), 36'd1);
        write_n(1);
        chk("R7 ae at 17", 36'(almost_empty), 36'd0);
        write_n(30);
        chk("R8 af at 47", 36'(almost_full), 36'd0);
        write_n(1);
        chk("R8 af at 48", 36'(almost_full), 36'd1);
        write_n(16);
        chk("R4 wr_stat full", 36'(wr_stat), 36'd0);
        next_val = 999;
        write_n(1);
        for (int i = 0; i < DEPTH; i++) begin
            read1();
            chk("R3 drain order", rd_data, 36'(100 + i));
        end
        chk("R4 dropped write", 36'(rd_stat), 36'd0);

        // R2 clamp of code 4 and fallback of code 7
        mreset(3'd4, 1'b0);
        chk("R2 clamp af empty", 36'(almost_full), 36'd1);
        write_n(DEPTH);
        chk("R2 clamp ae full", 36'(almost_empty), 36'd1);
        mreset(3'd7, 1'b0);
        write_n(8);
        chk("R2 fallback ae 8", 36'(almost_empty), 36'd1);
        write_n(1);
        chk("R2 fallback ae 9", 36'(almost_empty), 36'd0);

        // R9 parallel load with competing serial shift
        mreset(3'd0, 1'b0);
        off_we = 1'b1; ser_en = 1'b1; ser_bit = 1'b1;
        off_sel = 1'b1; off_data = OW'(5); tick();
        off_sel = 1'b0; off_data = OW'(3); tick();
        off_we = 1'b0; ser_en = 1'b0;
        write_n(3);
        chk("R9 ae at 3", 36'(almost_empty), 36'd1);
        write_n(1);
        chk("R9 ae at 4", 36'(almost_empty), 36'd0);
        write_n(54);
        chk("R9 af at 58", 36'(almost_full), 36'd0);
        write_n(1);
        chk("R9 af at 59", 36'(almost_full), 36'd1);

        // R10 serial load (ae=2, af=1), then R11 partial reset keeps them
        begin
            logic [2*OW-1:0] bits;
            bits = {OW'(2), OW'(1)};
            for (int i = 2*OW-1; i >= 0; i--) begin
                ser_en = 1'b1; ser_bit = bits[i]; tick();
            end
            ser_en = 1'b0;
        end
        preset_clear();
        chk("R11 rd_stat cleared", 36'(rd_stat), 36'd0);
        chk("R11 wr_stat cleared", 36'(wr_stat), 36'd1);
        write_n(2);
        chk("R10 ae at 2", 36'(almost_empty), 36'd1);
        write_n(1);
        chk("R10 ae at 3", 36'(almost_empty), 36'd0);
        write_n(59);
        chk("R10 af at 62", 36'(almost_full), 36'd0);
        write_n(1);
        chk("R10 af at 63", 36'(almost_full), 36'd1);

        // R5 fall-through
        mreset(3'd0, 1'b1);
        wr_en = 1'b1; wr_data = 36'hA5; tick(); wr_en = 1'b0;
        chk("R5 not yet ready", 36'(rd_stat), 36'd0);
        tick();
        chk("R5 ready", 36'(rd_stat), 36'd1);
        chk("R5 shown word", rd_data, 36'hA5);
        next_val = 36'hB6; write_n(1);
        next_val = 36'hC7; write_n(1);
        read1();
        chk("R5 advance", rd_data, 36'hB6);
        read1();
        chk("R5 advance 2", rd_data, 36'hC7);
        read1();
        chk("R5 drained", 36'(rd_stat), 36'd0);

        // R8 fall-through capacity DEPTH+1
        write_n(DEPTH);
        chk("R8 room at DEPTH", 36'(wr_stat), 36'd1);
        write_n(1);
        chk("R8 full at DEPTH+1", 36'(wr_stat), 36'd0);
        chk("R8 af at DEPTH+1", 36'(almost_full), 36'd1);

        // R11 partial reset keeps fall-through mode
        preset_clear();
        chk("R11 fwft cleared", 36'(rd_stat), 36'd0);
        chk("R11 fwft rd_data", rd_data, 36'd0);
        next_val = 36'hD8; write_n(1);
        chk("R11 mode kept wait", 36'(rd_stat), 36'd0);
        tick();
        chk("R11 mode kept word", rd_data, 36'hD8);

        // R12 retransmit
        mreset(3'd0, 1'b0);
        next_val = 5; write_n(3);
        read1();
        chk("R12 first read", rd_data, 36'd5);
        rt_mark = 1'b1; tick(); rt_mark = 1'b0;
        read1(); read1();
        chk("R12 last read", rd_data, 36'd7);
        chk("R12 empty before rewind", 36'(rd_stat), 36'd0);
        rt_go = 1'b1; wr_en = 1'b1; wr_data = 36'd99; tick();
        rt_go = 1'b0; wr_en = 1'b0;
        chk("R12 rewind ready", 36'(rd_stat), 36'd1);
        read1();
        chk("R12 replay 1", rd_data, 36'd6);
        read1();
        chk("R12 replay 2", rd_data, 36'd7);
        chk("R12 write ignored", 36'(rd_stat), 36'd0);
        prst_n = 1'b0; rt_go = 1'b1; tick();
        prst_n = 1'b1; rt_go = 1'b0;
        chk("R12 ignored in reset", 36'(rd_stat), 36'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule